// File: doc/BRIEF.md
# Precise Exception Tracker for a Five-Stage In-Order Pipeline

This block follows the exception status of every instruction in a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each stage may raise its own fault causes. A cause is recorded when it is raised and then travels with the instruction in a per-slot status register. The instruction's PC travels with it as well.

The status is acted on at one point only: the end of the memory stage. An instruction that reaches that point with a cause is reported on a one-cycle trap pulse, together with its PC and cause code. In the same cycle the block raises a flush. The flush turns every younger instruction into a bubble and keeps the faulting instruction itself from writing memory or the register file. Because only the oldest instruction can be at the commit point, a younger instruction that faults earlier in time can never be reported before an older one.

The surrounding pipeline supplies the fetch slot (valid and PC), one fault strobe group per stage and a stall. The datapath, the trap handler and address translation are not part of this block.

Top module: `pexc_tracker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, flush_o, trap_o, mem_wr_ok_o and rf_wr_ok_o are 0, and trap_pc_o and trap_cause_o are 0.
- R2: The fetch fault strobe if_fault_i uses bit0 for page fault (cause 1), bit1 for misaligned (cause 2) and bit2 for protection (cause 3). When several bits are set in one cycle, the lowest set bit supplies the cause.
- R3: id_illegal_i gives cause 4 (illegal opcode) to the instruction in decode. ex_arith_i gives cause 5 (arithmetic) to the instruction in execute.
- R4: The memory fault strobe mem_fault_i uses bit0 for data page fault (cause 6), bit1 for data misaligned (cause 7) and bit2 for data protection (cause 8). When several bits are set, the lowest set bit wins.
- R5: When one instruction collects causes in more than one stage, the cause from the earliest stage is the one reported. Cause 0 means no fault.
- R6: With no stall, an instruction offered at fetch in cycle n that carries a cause makes flush_o high in cycle n+3, which is the cycle it spends in memory. trap_o is then high for exactly cycle n+4, with trap_pc_o equal to that instruction's fetch PC and trap_cause_o equal to its cause.
- R7: When a younger instruction raises a fault before an older one, and the older one then faults in a later stage, only the older instruction is reported. The younger one never produces a trap.
- R8: A faulting instruction never writes. mem_wr_ok_o is 0 in its memory cycle and rf_wr_ok_o is 0 in the cycle after it. Any valid instruction without a cause has mem_wr_ok_o high in its memory cycle and rf_wr_ok_o high in its writeback cycle.
- R9: Every instruction that sits in fetch, decode or execute during a flush cycle becomes a bubble. None of them later raises mem_wr_ok_o, rf_wr_ok_o or trap_o.
- R10: While stall_i is high, no status register changes and flush_o stays 0. A fault that is pending at commit during a stall is reported in the first cycle without a stall, with its trap one cycle after that.
- R11: Fault strobes of a stage that holds no valid instruction have no effect: they cause no flush and no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Holds every slot and blocks commit |
| fetch_valid_i | input | 1 | A valid instruction is in the fetch slot |
| fetch_pc_i | input | PC_W | PC of the instruction in fetch |
| if_fault_i | input | 3 | Fetch fault strobes: page, misaligned, protection |
| id_illegal_i | input | 1 | Decode found an illegal opcode |
| ex_arith_i | input | 1 | Execute raised an arithmetic fault |
| mem_fault_i | input | 3 | Memory fault strobes: page, misaligned, protection |
| flush_o | output | 1 | Commit of a faulting instruction: kill all younger slots |
| trap_o | output | 1 | One-cycle trap request |
| trap_pc_o | output | PC_W | PC of the reported instruction |
| trap_cause_o | output | 4 | Cause code of the reported instruction |
| mem_wr_ok_o | output | 1 | Instruction in memory stage may write memory |
| rf_wr_ok_o | output | 1 | Instruction in writeback may write the register file |

## Verification
flush_o and mem_wr_ok_o are combinational from the memory slot and the memory strobes, so they are due in the same cycle an instruction spends in memory: three cycles after its fetch cycle when nothing stalls. trap_o, trap_pc_o and trap_cause_o are registered, so they come one cycle later. rf_wr_ok_o comes four cycles after fetch. The bench drives inputs on the falling edge and samples 4 ns later, before the next rising edge. For each cycle it works out which instruction index sits in each stage, and from that the expected value of every output. Stall cycles shift that schedule by one cycle each, and the stall scenario counts them in its expected cycle numbers.

// File: rtl/pexc_pkg.sv
package pexc_pkg;

   localparam int CAUSE_W    = 4;
   localparam int STRB_W     = 3;
   localparam int NUM_SLOTS  = 4;   // decode, execute, memory, writeback
   localparam int NUM_FSTAGE = 4;   // stages that may raise a cause

   typedef enum logic [CAUSE_W-1:0] {
      XC_NONE    = 4'd0,
      XC_I_PAGE  = 4'd1,
      XC_I_ALIGN = 4'd2,
      XC_I_PROT  = 4'd3,
      XC_ILLEGAL = 4'd4,
      XC_ARITH   = 4'd5,
      XC_D_PAGE  = 4'd6,
      XC_D_ALIGN = 4'd7,
      XC_D_PROT  = 4'd8
   } xcause_e;

   // first cause code owned by each faulting stage
   function automatic logic [CAUSE_W-1:0] stage_base(input int s);
      case (s)
         0:       return XC_I_PAGE;
         1:       return XC_ILLEGAL;
         2:       return XC_ARITH;
         default: return XC_D_PAGE;
      endcase
   endfunction

endpackage

// File: rtl/pexc_fault_enc.sv
module pexc_fault_enc
   import pexc_pkg::*;
#(
   parameter int                 N_STRB = 3,
   parameter logic [CAUSE_W-1:0] BASE   = 4'd1
)(
   input  logic [N_STRB-1:0]  strb_i,
   output logic [CAUSE_W-1:0] code_o
);

   initial begin
      if (N_STRB < 1 || N_STRB > 8)
         $error("pexc_fault_enc: N_STRB out of range");
   end

   // lowest set strobe selects the code
   always_comb begin
      code_o = '0;
      for (int i = N_STRB-1; i >= 0; i--) begin
         if (strb_i[i]) code_o = BASE + CAUSE_W'(i);
      end
   end

endmodule

// File: rtl/pexc_merge.sv
module pexc_merge
   import pexc_pkg::*;
(
   input  logic               valid_i,
   input  logic [CAUSE_W-1:0] prior_i,
   input  logic [CAUSE_W-1:0] local_i,
   output logic [CAUSE_W-1:0] eff_o
);

   // an earlier stage's cause is never overwritten; bubbles carry none
   always_comb begin
      if (!valid_i)            eff_o = '0;
      else if (prior_i != '0)  eff_o = prior_i;
      else                     eff_o = local_i;
   end

endmodule

// File: rtl/pexc_slot.sv
module pexc_slot
   import pexc_pkg::*;
#(
   parameter int PC_W = 32
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               adv_i,
   input  logic               kill_i,
   input  logic               valid_i,
   input  logic [PC_W-1:0]    pc_i,
   input  logic [CAUSE_W-1:0] cause_i,
   output logic               valid_o,
   output logic [PC_W-1:0]    pc_o,
   output logic [CAUSE_W-1:0] cause_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         pc_o    <= '0;
         cause_o <= '0;
      end else if (adv_i) begin
         valid_o <= valid_i & ~kill_i;
         pc_o    <= pc_i;
         cause_o <= kill_i ? '0 : cause_i;
      end
   end

endmodule

// File: rtl/pexc_tracker.sv
module pexc_tracker
   import pexc_pkg::*;
#(
   parameter int PC_W = 32
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stall_i,
   input  logic               fetch_valid_i,
   input  logic [PC_W-1:0]    fetch_pc_i,
   input  logic [2:0]         if_fault_i,
   input  logic               id_illegal_i,
   input  logic               ex_arith_i,
   input  logic [2:0]         mem_fault_i,
   output logic               flush_o,
   output logic               trap_o,
   output logic [PC_W-1:0]    trap_pc_o,
   output logic [CAUSE_W-1:0] trap_cause_o,
   output logic               mem_wr_ok_o,
   output logic               rf_wr_ok_o
);

   localparam int NST    = NUM_SLOTS + 1;   // fetch plus held slots
   localparam int COMMIT = NUM_FSTAGE - 1;  // memory stage index

   initial begin
      if (PC_W < 2) $error("pexc_tracker: PC_W must be at least 2");
   end

   logic               st_v  [NST];
   logic [PC_W-1:0]    st_pc [NST];
   logic [CAUSE_W-1:0] st_cz [NST];
   logic [CAUSE_W-1:0] st_ez [NUM_FSTAGE];
   logic [STRB_W-1:0]  strb  [NUM_FSTAGE];
   logic [CAUSE_W-1:0] lcode [NUM_FSTAGE];
   logic               adv;
   logic               commit_fault;

   assign st_v[0]  = fetch_valid_i;
   assign st_pc[0] = fetch_pc_i;
   assign st_cz[0] = '0;

   assign strb[0] = if_fault_i;
   assign strb[1] = {2'b00, id_illegal_i};
   assign strb[2] = {2'b00, ex_arith_i};
   assign strb[3] = mem_fault_i;

   assign adv = ~stall_i;

   // per-stage cause encoding and merge with the carried cause
   for (genvar s = 0; s < NUM_FSTAGE; s++) begin : g_stage
      pexc_fault_enc #(
         .N_STRB (STRB_W),
         .BASE   (stage_base(s))
      ) u_enc (
         .strb_i (strb[s]),
         .code_o (lcode[s])
      );

      pexc_merge u_merge (
         .valid_i (st_v[s]),
         .prior_i (st_cz[s]),
         .local_i (lcode[s]),
         .eff_o   (st_ez[s])
      );
   end

   // held slots: decode, execute, memory, writeback
   for (genvar s = 1; s < NST; s++) begin : g_slot
      logic [CAUSE_W-1:0] cz_in;
      if (s - 1 < NUM_FSTAGE) begin : g_fed
         assign cz_in = st_ez[s-1];
      end else begin : g_tail
         assign cz_in = st_cz[s-1];
      end

      pexc_slot #(
         .PC_W (PC_W)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .adv_i   (adv),
         .kill_i  (flush_o),
         .valid_i (st_v[s-1]),
         .pc_i    (st_pc[s-1]),
         .cause_i (cz_in),
         .valid_o (st_v[s]),
         .pc_o    (st_pc[s]),
         .cause_o (st_cz[s])
      );
   end

   // commit point at the end of the memory stage
   assign commit_fault = st_v[COMMIT] & (st_ez[COMMIT] != '0);
   assign flush_o      = commit_fault & adv;
   assign mem_wr_ok_o  = st_v[COMMIT] & (st_ez[COMMIT] == '0);
   assign rf_wr_ok_o   = st_v[NST-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trap_o       <= 1'b0;
         trap_pc_o    <= '0;
         trap_cause_o <= '0;
      end else begin
         trap_o <= flush_o;
         if (flush_o) begin
            trap_pc_o    <= st_pc[COMMIT];
            trap_cause_o <= st_ez[COMMIT];
         end
      end
   end

endmodule

// File: rtl/pexc_tracker_chk.sv
module pexc_tracker_chk
   import pexc_pkg::*;
#(
   parameter int PC_W = 32
)(
   input logic               clk,
   input logic               rst_n,
   input logic               stall_i,
   input logic               flush_o,
   input logic               trap_o,
   input logic [CAUSE_W-1:0] trap_cause_o,
   input logic               mem_wr_ok_o,
   input logic               rf_wr_ok_o
);

   AST_TRAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |=> !trap_o); // R6

   AST_FLUSH_TO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |=> trap_o); // R6

   AST_TRAP_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> (trap_cause_o != '0) && (trap_cause_o <= 4'd8)); // R5

   AST_NO_MEM_WRITE_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> !mem_wr_ok_o); // R8

   AST_NO_RF_WRITE_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |=> !rf_wr_ok_o); // R8

   AST_STALL_BLOCKS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      stall_i |-> !flush_o); // R10

   AST_STALL_HOLDS_WB: assert property (@(posedge clk) disable iff (!rst_n)
      stall_i |=> $stable(rf_wr_ok_o)); // R10

   AST_BUBBLES_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |=> !flush_o); // R9

endmodule

bind pexc_tracker pexc_tracker_chk #(.PC_W(PC_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .stall_i      (stall_i),
   .flush_o      (flush_o),
   .trap_o       (trap_o),
   .trap_cause_o (trap_cause_o),
   .mem_wr_ok_o  (mem_wr_ok_o),
   .rf_wr_ok_o   (rf_wr_ok_o)
);

// File: tb/pexc_tracker_tb.sv
module pexc_tracker_tb;

   localparam int PC_W = 32;
   localparam int NI   = 6;   // instructions per case
   localparam int JF   = 1;   // index of the older faulting instruction
   localparam int NCYC = 12;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            stall_i;
   logic            fetch_valid_i;
   logic [PC_W-1:0] fetch_pc_i;
   logic [2:0]      if_fault_i;
   logic            id_illegal_i;
   logic            ex_arith_i;
   logic [2:0]      mem_fault_i;
   logic            flush_o;
   logic            trap_o;
   logic [PC_W-1:0] trap_pc_o;
   logic [3:0]      trap_cause_o;
   logic            mem_wr_ok_o;
   logic            rf_wr_ok_o;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   pexc_tracker #(.PC_W(PC_W)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .stall_i       (stall_i),
      .fetch_valid_i (fetch_valid_i),
      .fetch_pc_i    (fetch_pc_i),
      .if_fault_i    (if_fault_i),
      .id_illegal_i  (id_illegal_i),
      .ex_arith_i    (ex_arith_i),
      .mem_fault_i   (mem_fault_i),
      .flush_o       (flush_o),
      .trap_o        (trap_o),
      .trap_pc_o     (trap_pc_o),
      .trap_cause_o  (trap_cause_o),
      .mem_wr_ok_o   (mem_wr_ok_o),
      .rf_wr_ok_o    (rf_wr_ok_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      stall_i       = 1'b0;
      fetch_valid_i = 1'b0;
      fetch_pc_i    = '0;
      if_fault_i    = '0;
      id_illegal_i  = 1'b0;
      ex_arith_i    = 1'b0;
      mem_fault_i   = '0;
   endtask

   // cause from an 8-bit mask: [2:0] fetch, [3] decode, [4] execute, [7:5] memory
   function automatic logic [3:0] exp_cause(input logic [7:0] m);
      if (m[0]) return 4'd1;
      if (m[1]) return 4'd2;
      if (m[2]) return 4'd3;
      if (m[3]) return 4'd4;
      if (m[4]) return 4'd5;
      if (m[5]) return 4'd6;
      if (m[6]) return 4'd7;
      if (m[7]) return 4'd8;
      return 4'd0;
   endfunction

   function automatic bit writes(input int k);
      return (k >= 0) && (k < NI) && ((k < JF) || (k >= JF + 4));
   endfunction

   // one stream: older instruction JF carries mask m, younger JF+1 carries
   // an early fault selected by yf (0 none, 1..3 fetch bit, 4 decode, 5 execute)
   task automatic run_case(input logic [7:0] m, input int yf);
      logic [31:0] base;
      base = {16'h0, m, 8'h00} + 32'(yf) * 32'h0010_0000;
      for (int c = 0; c < NCYC; c++) begin
         @(negedge clk);
         idle_inputs();
         fetch_valid_i = (c < NI);
         fetch_pc_i    = base + 32'(4 * c);
         if (c == JF)     if_fault_i = m[2:0];
         if (c == JF + 1 && yf >= 1 && yf <= 3) if_fault_i = 3'(1 << (yf - 1));
         id_illegal_i = (c == JF + 1 && m[3]) || (c == JF + 2 && yf == 4);
         ex_arith_i   = (c == JF + 2 && m[4]) || (c == JF + 3 && yf == 5);
         if (c == JF + 3) mem_fault_i = m[7:5];
         #4;
         chk("R6", "flush", 32'(flush_o), 32'(c == JF + 3));
         chk("R7", "trap", 32'(trap_o), 32'(c == JF + 4));
         if (c == JF + 4) begin
            chk("R6", "trap_pc", trap_pc_o, base + 32'(4 * JF));
            chk("R5", "trap_cause", 32'(trap_cause_o), 32'(exp_cause(m)));
         end
         chk("R8", "mem_wr_ok", 32'(mem_wr_ok_o), 32'(writes(c - 3)));
         chk("R9", "rf_wr_ok", 32'(rf_wr_ok_o), 32'(writes(c - 4)));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      idle_inputs();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #4;
      chk("R1", "flush in reset", 32'(flush_o), 0);
      chk("R1", "trap in reset", 32'(trap_o), 0);
      chk("R1", "trap_pc in reset", trap_pc_o, 0);
      chk("R1", "trap_cause in reset", 32'(trap_cause_o), 0);
      chk("R1", "mem_wr_ok in reset", 32'(mem_wr_ok_o), 0);
      chk("R1", "rf_wr_ok in reset", 32'(rf_wr_ok_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #4;
      chk("R1", "trap after reset", 32'(trap_o), 0);
      chk("R1", "rf_wr_ok after reset", 32'(rf_wr_ok_o), 0);

      // R11: strobes on an empty pipeline
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         idle_inputs();
         if_fault_i = 3'b111; id_illegal_i = 1'b1;
         ex_arith_i = 1'b1;   mem_fault_i  = 3'b111;
         #4;
         chk("R11", "flush on bubbles", 32'(flush_o), 0);
         chk("R11", "trap on bubbles", 32'(trap_o), 0);
      end

      // R2 R3 R4 R5 R6 R7 R8 R9: every nonzero cause mask, six younger patterns
      for (int yf = 0; yf < 6; yf++) begin
         for (int m = 1; m < 256; m++) begin
            run_case(8'(m), yf);
         end
      end

      // R10: fetch fault, stalled in execute (cycles 2..4) and at commit (cycle 6)
      for (int c = 0; c < 11; c++) begin
         @(negedge clk);
         idle_inputs();
         fetch_valid_i = (c == 0);
         fetch_pc_i    = 32'hABC0;
         if (c == 0) if_fault_i = 3'b001;
         stall_i = (c >= 2 && c <= 4) || (c == 6);
         #4;
         chk("R10", "flush with stall", 32'(flush_o), 32'(c == 7));
         chk("R10", "trap with stall", 32'(trap_o), 32'(c == 8));
         chk("R10", "mem_wr_ok with stall", 32'(mem_wr_ok_o), 0);
         if (c == 8) begin
            chk("R10", "trap_pc after stall", trap_pc_o, 32'hABC0);
            chk("R2", "cause after stall", 32'(trap_cause_o), 1);
         end
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule